// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

The unit watches every access a processor makes on its bus and raises a break request toward the core when an access meets a programmed condition. It has two channels. Each channel has a compare address with a don't-care bit mask, which lets one channel cover an aligned range of addresses. Each channel also has a cycle condition. That condition selects which bus is watched, instruction fetch or data access, read or write, and either one required access size or no size check at all.

A channel that watches instruction fetches can fire before the instruction runs or after it runs. Before-execution breaks, and breaks on data accesses, assert the request in the cycle of the matching access. After-execution breaks wait for the core's instruction-executed strobe. The second channel has two further features. It can compare the bus data value under a data mask. It can also count matches and fire only on the Nth one. The two channels fire independently, and a hit on either one raises the request.

Software programs the unit through a simple write-only register port. It reads which channel fired from two sticky match flags.

Top module: `brkpt_unit`

## Requirements
- R1: A channel's address condition holds when `((busAddr ^ base) & ~mask) == 0`. A set mask bit makes that address bit a don't-care. For example, base 0x8404 with mask 0xFFF covers 0x8000 through 0x8FFF, and mask 0 requires the exact address.
- R2: Condition bits [1:0] select the access kind. The codes are 00 for channel off, 01 for instruction fetch only, 10 for data access only, and 11 for either. Bit 2 allows reads and bit 3 allows writes, where `busWrite`=1 marks a write.
- R3: Condition bits [5:4] give the size rule. 00 means size is not checked. 01, 10 and 11 require a byte, word or longword access, which `busSize` encodes as 00, 01 and 10.
- R4: Condition bit 6 must equal `busSel` for a match, so the condition chooses which of two buses is watched.
- R5: When a match occurs with condition bit 7 clear, or on a data access, `brkReq` is high in the same cycle as the qualifying `busValid` access and only for that cycle.
- R6: A fetch match with condition bit 7 set raises no request in the fetch cycle. The request comes exactly one cycle after the next `instrExec` pulse and lasts one cycle.
- R7: When channel B condition bit 8 is set, B also requires `((busData ^ dataVal) & ~dataMask) == 0`. A zero data mask demands every data bit.
- R8: When channel B condition bit 9 is set, each B match with a nonzero count decrements the count. Only the match taken at count 1 fires. With count 5, matches 1 to 4 pass and match 5 breaks. Later matches stay silent until the count is written again.
- R9: `matchA` and `matchB` rise in the cycle after their channel fires. They stay set until a write to the clear register, where bit 0 clears A and bit 1 clears B. A fire in the same cycle as the clear leaves the flag set.
- R10: A fire on either channel alone raises `brkReq`. Both channels firing in the same cycle give one single-cycle request and set both flags.
- R11: The configuration offsets on `cfgAddr` are as follows. Channel A uses 0 for base, 1 for mask and 2 for condition. Channel B uses 3 for base, 4 for mask and 5 for condition. 6 is the data value, 7 the data mask, 8 the count and 9 the flag clear. After reset every channel is off and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register offset |
| cfgWdata | input | 32 | Configuration write data |
| busValid | input | 1 | A bus access is present this cycle |
| busSel | input | 1 | Which bus carries the access |
| busFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 00 byte, 01 word, 10 longword |
| busAddr | input | 32 | Access address |
| busData | input | 32 | Access data |
| instrExec | input | 1 | The oldest pending fetched instruction has executed |
| brkReq | output | 1 | Break request pulse |
| matchA | output | 1 | Sticky channel A fired flag |
| matchB | output | 1 | Sticky channel B fired flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is both channels matching one access. The bench sets both channels to the same fetch address and expects one request pulse and both flags set. The second pair is a flag-clear write and a new fire. The bench drives the clear write and a matching access at the same clock edge and expects the flag to read set afterwards. The bench also sweeps the mask ranges and the full cross product of the cycle condition codes, and it computes each expected request by arithmetic.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
  localparam int NUM_CH = 2;
  localparam int CFG_W  = 32;

  localparam logic [3:0] OFF_A_BASE = 4'd0;
  localparam logic [3:0] OFF_B_BASE = 4'd3;
  localparam logic [3:0] OFF_DVAL   = 4'd6;
  localparam logic [3:0] OFF_DMASK  = 4'd7;
  localparam logic [3:0] OFF_COUNT  = 4'd8;
  localparam logic [3:0] OFF_CLEAR  = 4'd9;

  // channel condition word, bit 0 at the bottom
  typedef struct packed {
    logic       cntEn;   // [9]
    logic       dataEn;  // [8]
    logic       after;   // [7]
    logic       sel;     // [6]
    logic [1:0] size;    // [5:4]
    logic       wrEn;    // [3]
    logic       rdEn;    // [2]
    logic [1:0] kind;    // [1:0]
  } cond_t;

  localparam int COND_W = $bits(cond_t);

  // control -> datapath
  typedef struct packed {
    logic cntDec;
  } ctrl_stb_t;

  // datapath -> control
  typedef struct packed {
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] afterMode;
    logic [NUM_CH-1:0] clrFlag;
    logic              cntEn;
    logic              cntOne;
    logic              cntZero;
  } dp_stat_t;
endpackage

// File: rtl/brkpt_datapath.sv
module brkpt_datapath
  import brkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [3:0]        cfgAddr,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              busValid,
  input  logic              busSel,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  ctrl_stb_t         stb,
  output dp_stat_t          stat
);
  localparam int LAST_CH = NUM_CH - 1;

  logic [DATA_W-1:0] dataVal;
  logic [DATA_W-1:0] dataMask;
  logic [CNT_W-1:0]  cnt;
  logic              dataMatch;
  logic [NUM_CH-1:0] hitVec;
  logic [NUM_CH-1:0] afterVec;
  logic              lastCntEn;

  // data value registers, channel B only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataVal  <= '0;
      dataMask <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == OFF_DVAL)  dataVal  <= cfgWdata[DATA_W-1:0];
      if (cfgAddr == OFF_DMASK) dataMask <= cfgWdata[DATA_W-1:0];
    end
  end

  assign dataMatch = ((busData ^ dataVal) & ~dataMask) == '0;

  // occurrence counter: reload on write, decrement on strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt <= '0;
    else if (cfgWe && cfgAddr == OFF_COUNT)   cnt <= cfgWdata[CNT_W-1:0];
    else if (stb.cntDec)                      cnt <= cnt - 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [3:0] OFF_BASE = OFF_A_BASE + 4'(3 * ch);
    logic [ADDR_W-1:0] baseR;
    logic [ADDR_W-1:0] maskR;
    cond_t             condR;
    logic addrOk, kindOk, rwOk, sizeOk, selOk, dataOk;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        baseR <= '0;
        maskR <= '0;
        condR <= '0;
      end else if (cfgWe) begin
        if (cfgAddr == OFF_BASE)        baseR <= cfgWdata[ADDR_W-1:0];
        if (cfgAddr == OFF_BASE + 4'd1) maskR <= cfgWdata[ADDR_W-1:0];
        if (cfgAddr == OFF_BASE + 4'd2) condR <= cond_t'(cfgWdata[COND_W-1:0]);
      end
    end

    assign addrOk = ((busAddr ^ baseR) & ~maskR) == '0;
    assign kindOk = (condR.kind == 2'b11) ||
                    (condR.kind == 2'b01 &&  busFetch) ||
                    (condR.kind == 2'b10 && !busFetch);
    assign rwOk   = busWrite ? condR.wrEn : condR.rdEn;
    assign sizeOk = (condR.size == 2'b00) || (condR.size == busSize + 2'd1);
    assign selOk  = (condR.sel == busSel);

    if (ch == LAST_CH) begin : g_data
      assign dataOk    = !condR.dataEn || dataMatch;
      assign lastCntEn = condR.cntEn;
    end else begin : g_nodata
      assign dataOk = 1'b1;
    end

    assign hitVec[ch]   = busValid && addrOk && kindOk && rwOk && sizeOk && selOk && dataOk;
    assign afterVec[ch] = condR.after && busFetch;
  end

  always_comb begin
    stat           = '0;
    stat.hit       = hitVec;
    stat.afterMode = afterVec;
    stat.cntEn     = lastCntEn;
    stat.cntOne    = (cnt == CNT_W'(1));
    stat.cntZero   = (cnt == '0);
    stat.clrFlag   = (cfgWe && cfgAddr == OFF_CLEAR) ? cfgWdata[NUM_CH-1:0] : '0;
  end
endmodule

// File: rtl/brkpt_ctrl.sv
module brkpt_ctrl
  import brkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instrExec,
  input  dp_stat_t          stat,
  output ctrl_stb_t         stb,
  output logic              brkReq,
  output logic [NUM_CH-1:0] matchFlag
);
  localparam int LAST_CH = NUM_CH - 1;

  logic [NUM_CH-1:0] gate, qual, fireNow, pend, afterFire, fire;

  always_comb begin
    gate          = '1;
    gate[LAST_CH] = !stat.cntEn || stat.cntOne;
  end

  assign qual       = stat.hit & gate;
  assign fireNow    = qual & ~stat.afterMode;
  assign stb.cntDec = stat.hit[LAST_CH] && stat.cntEn && !stat.cntZero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      afterFire <= '0;
    end else begin
      pend      <= (qual & stat.afterMode) | (pend & ~{NUM_CH{instrExec}});
      afterFire <= pend & {NUM_CH{instrExec}};
    end
  end

  assign fire   = fireNow | afterFire;
  assign brkReq = |fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) matchFlag <= '0;
    else        matchFlag <= fire | (matchFlag & ~stat.clrFlag);
  end
endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
  import brkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [3:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              busValid,
  input  logic              busSel,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              instrExec,
  output logic              brkReq,
  output logic              matchA,
  output logic              matchB
);
  ctrl_stb_t         stb;
  dp_stat_t          stat;
  logic [NUM_CH-1:0] flags;

  brkpt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .busValid(busValid), .busSel(busSel), .busFetch(busFetch), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busData(busData), .stb(stb), .stat(stat)
  );

  brkpt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .instrExec(instrExec), .stat(stat),
    .stb(stb), .brkReq(brkReq), .matchFlag(flags)
  );

  assign matchA = flags[0];
  assign matchB = flags[1];
endmodule

// File: rtl/brkpt_checker.sv
module brkpt_checker
  import brkpt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfgWe,
  input logic [3:0]  cfgAddr,
  input logic [31:0] cfgWdata,
  input logic        brkReq,
  input logic        matchA,
  input dp_stat_t    stat
);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    matchA && !(cfgWe && cfgAddr == OFF_CLEAR && cfgWdata[0]) |=> matchA);

  a_r9_flag_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matchA) |-> $past(brkReq));

  a_r8_count_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    stat.cntZero && !(cfgWe && cfgAddr == OFF_COUNT) |=> stat.cntZero);

  a_r5_before_fires_now: assert property (@(posedge clk) disable iff (!rst_n)
    stat.hit[0] && !stat.afterMode[0] |-> brkReq);
endmodule

bind brkpt_unit brkpt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
  .brkReq(brkReq), .matchA(matchA), .stat(stat)
);

// File: tb/brkpt_unit_tb.sv
`timescale 1ns/1ps
module brkpt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        busValid = 1'b0, busSel = 1'b0, busFetch = 1'b0, busWrite = 1'b0;
  logic [1:0]  busSize = '0;
  logic [31:0] busAddr = '0, busData = '0;
  logic        instrExec = 1'b0;
  logic        brkReq, matchA, matchB;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;

  brkpt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .busValid(busValid), .busSel(busSel), .busFetch(busFetch), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busData(busData), .instrExec(instrExec),
    .brkReq(brkReq), .matchA(matchA), .matchB(matchB)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCond(input int kind, input int rw, input int sz,
                                         input int sel, input int after, input int dEn,
                                         input int cEn);
    return 32'((cEn << 9) | (dEn << 8) | (after << 7) | (sel << 6) | (sz << 4) | (rw << 2) | kind);
  endfunction

  task automatic wr(input logic [3:0] off, input logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = off; cfgWdata = val;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  // one access; returns brkReq sampled mid-cycle
  task automatic acc(input logic f, input logic w, input logic [1:0] sz, input logic s,
                     input logic [31:0] a, input logic [31:0] d, output logic req);
    @(negedge clk);
    busValid = 1'b1; busFetch = f; busWrite = w; busSize = sz; busSel = s;
    busAddr = a; busData = d;
    #5 req = brkReq;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic idleSample(output logic req);
    @(negedge clk);
    #5 req = brkReq;
  endtask

  initial begin
    #(20 * 200000);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(brkReq, 1'b0, "R11", "reset brkReq");
    check(matchA, 1'b0, "R11", "reset matchA");
    check(matchB, 1'b0, "R11", "reset matchB");
    acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h0, 32'h0, r);
    check(r, 1'b0, "R11", "channels off after reset");

    // R1: masked range sweep on channel A
    wr(4'd0, 32'h8404); wr(4'd1, 32'h0FFF); wr(4'd2, mkCond(1, 1, 3, 0, 0, 0, 0));
    for (int a = 32'h7F00; a <= 32'h9100; a += 2) begin
      acc(1'b1, 1'b0, 2'd2, 1'b0, 32'(a), 32'h0, r);
      check(r, (a >= 32'h8000 && a <= 32'h8FFF), "R1", $sformatf("range A addr %h", a));
    end
    wr(4'd2, 32'h0);
    // R1: small mask on channel B
    wr(4'd3, 32'h8010); wr(4'd4, 32'h6); wr(4'd5, mkCond(1, 1, 0, 0, 0, 0, 0));
    for (int a = 32'h8000; a <= 32'h8020; a++) begin
      acc(1'b1, 1'b0, 2'd1, 1'b0, 32'(a), 32'h0, r);
      check(r, ((a & ~32'h6) == 32'h8010), "R1", $sformatf("mask B addr %h", a));
    end
    // R1: zero mask exact
    wr(4'd3, 32'h500); wr(4'd4, 32'h0);
    for (int a = 32'h4F8; a <= 32'h508; a++) begin
      acc(1'b1, 1'b0, 2'd2, 1'b0, 32'(a), 32'h0, r);
      check(r, (a == 32'h500), "R1", $sformatf("exact B addr %h", a));
    end
    wr(4'd5, 32'h0);

    // R2 R3 R4: condition cross product on channel A
    wr(4'd0, 32'h6000); wr(4'd1, 32'h0);
    for (int k = 0; k < 4; k++)
      for (int rw = 0; rw < 4; rw++)
        for (int sc = 0; sc < 4; sc++)
          for (int cs = 0; cs < 2; cs++) begin
            wr(4'd2, mkCond(k, rw, sc, cs, 0, 0, 0));
            for (int f = 0; f < 2; f++)
              for (int w = 0; w < 2; w++)
                for (int sz = 0; sz < 3; sz++)
                  for (int s = 0; s < 2; s++) begin
                    bit kOk, rOk, zOk, sOk;
                    kOk = (k == 3) || (k == 1 && f == 1) || (k == 2 && f == 0);
                    rOk = w ? rw[1] : rw[0];
                    zOk = (sc == 0) || (sc == sz + 1);
                    sOk = (cs == s);
                    acc(f[0], w[0], sz[1:0], s[0], 32'h6000, 32'h0, r);
                    check(r, kOk && rOk && zOk && sOk, "R2_R3_R4",
                          $sformatf("k%0d rw%0d sc%0d cs%0d f%0d w%0d sz%0d s%0d", k, rw, sc, cs, f, w, sz, s));
                  end
          end

    // R6: after-execution timing
    wr(4'd0, 32'h3000); wr(4'd2, mkCond(1, 1, 0, 0, 1, 0, 0));
    wr(4'd9, 32'h3);
    acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h3000, 32'h0, r);
    check(r, 1'b0, "R6", "no request in fetch cycle");
    idleSample(r);
    check(r, 1'b0, "R6", "no request before exec");
    @(negedge clk); instrExec = 1'b1;
    #5 check(brkReq, 1'b0, "R6", "no request in exec cycle");
    @(posedge clk); #1 instrExec = 1'b0;
    idleSample(r);
    check(r, 1'b1, "R6", "request one cycle after exec");
    idleSample(r);
    check(r, 1'b0, "R6", "request lasts one cycle");
    check(matchA, 1'b1, "R9", "flag A after late break");
    // R5: before break single cycle
    wr(4'd2, mkCond(1, 1, 0, 0, 0, 0, 0));
    acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h3000, 32'h0, r);
    check(r, 1'b1, "R5", "before break same cycle");
    idleSample(r);
    check(r, 1'b0, "R5", "before break one cycle");
    wr(4'd2, 32'h0);

    // R7: data compare on channel B
    wr(4'd3, 32'h2000); wr(4'd4, 32'h0); wr(4'd6, 32'h12345678); wr(4'd7, 32'h000000FF);
    wr(4'd5, mkCond(2, 1, 0, 0, 0, 1, 0));
    for (int i = 0; i < 256; i += 5) begin
      acc(1'b0, 1'b0, 2'd2, 1'b0, 32'h2000, 32'h12345600 | 32'(i), r);
      check(r, 1'b1, "R7", $sformatf("masked low byte %0d", i));
    end
    for (int b = 8; b < 32; b++) begin
      acc(1'b0, 1'b0, 2'd2, 1'b0, 32'h2000, 32'h12345678 ^ (32'h1 << b), r);
      check(r, 1'b0, "R7", $sformatf("data bit %0d mismatch", b));
    end
    wr(4'd7, 32'h0);
    acc(1'b0, 1'b0, 2'd2, 1'b0, 32'h2000, 32'h12345678, r);
    check(r, 1'b1, "R7", "zero mask exact data");
    acc(1'b0, 1'b0, 2'd2, 1'b0, 32'h2000, 32'h12345679, r);
    check(r, 1'b0, "R7", "zero mask bit0 mismatch");
    wr(4'd5, 32'h0);

    // R8: occurrence count on channel B
    wr(4'd3, 32'h1000); wr(4'd5, mkCond(1, 1, 3, 0, 0, 0, 1)); wr(4'd8, 32'd5);
    for (int n = 1; n <= 7; n++) begin
      acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h1004, 32'h0, r);
      check(r, 1'b0, "R8", "non-matching fetch");
      acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h1000, 32'h0, r);
      check(r, (n == 5), "R8", $sformatf("count 5 match %0d", n));
    end
    wr(4'd8, 32'd2);
    for (int n = 1; n <= 3; n++) begin
      acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h1000, 32'h0, r);
      check(r, (n == 2), "R8", $sformatf("count 2 match %0d", n));
    end
    wr(4'd5, 32'h0);

    // R9: sticky flags and clear
    wr(4'd9, 32'h3);
    @(negedge clk);
    check(matchA, 1'b0, "R9", "A cleared");
    check(matchB, 1'b0, "R9", "B cleared");
    wr(4'd0, 32'h4000); wr(4'd2, mkCond(1, 1, 0, 0, 0, 0, 0));
    acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h4000, 32'h0, r);
    repeat (3) @(negedge clk);
    check(matchA, 1'b1, "R9", "A sticky");
    check(matchB, 1'b0, "R9", "B untouched");
    // clear and fire in the same cycle: set wins
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'd9; cfgWdata = 32'h1;
    busValid = 1'b1; busFetch = 1'b1; busWrite = 1'b0; busSize = 2'd2; busSel = 1'b0;
    busAddr = 32'h4000;
    @(posedge clk); #1;
    cfgWe = 1'b0; busValid = 1'b0;
    @(negedge clk);
    check(matchA, 1'b1, "R9", "fire beats clear");
    wr(4'd9, 32'h1);
    @(negedge clk);
    check(matchA, 1'b0, "R9", "clear alone");

    // R10: both channels same cycle, then each alone
    wr(4'd3, 32'h4000); wr(4'd4, 32'h0); wr(4'd5, mkCond(1, 1, 0, 0, 0, 0, 0));
    acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h4000, 32'h0, r);
    check(r, 1'b1, "R10", "both channels request");
    idleSample(r);
    check(r, 1'b0, "R10", "single pulse");
    check(matchA, 1'b1, "R10", "A flag on joint fire");
    check(matchB, 1'b1, "R10", "B flag on joint fire");
    wr(4'd3, 32'h5000);
    acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h4000, 32'h0, r);
    check(r, 1'b1, "R10", "A alone");
    acc(1'b1, 1'b0, 2'd2, 1'b0, 32'h5000, 32'h0, r);
    check(r, 1'b1, "R10", "B alone");

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule